// File: doc/BRIEF.md
# VLAN-Aware Virtual Switch Forwarder

This block makes the forwarding decision for a small multi-port layer-2 switch that honours 802.1Q VLAN tags. It takes one frame header at a time: the ingress port, the destination and source MAC addresses, and an optional VLAN tag. It works out which VLAN the frame belongs to and checks that the ingress port may carry it. It then looks up the destination in a learned address table and returns an egress port mask. For each egress port it also says whether the tag must be inserted or stripped. Payload storage, the MAC/PHY layers and multicast filtering belong to other blocks.

Each port is set up by quasi-static configuration inputs. These give the port's tag awareness and its default VLAN. A small VLAN table holds, per entry, a VLAN ID, a member port mask and an optional trunk port. A unicast destination that has not been learned is sent only to the trunk port of its VLAN, not flooded. The address table is keyed on MAC and VLAN together. It learns the source of every frame that passes classification. When a known station shows up on another port, the block reports a move event that carries the old port.

The control is a five-state machine:
- ST_IDLE accepts a header while `hdr_ready` is high. Transition: go to ST_CLASSIFY on `hdr_valid`.
- ST_CLASSIFY registers the VLAN verdict. Transitions: go to ST_LOOKUP on accept, or to ST_REPORT on drop.
- ST_LOOKUP registers the destination hit and the source-move check. Transition: go to ST_LEARN.
- ST_LEARN writes the source entry and registers the egress mask and tag actions. Transition: go to ST_REPORT.
- ST_REPORT raises `res_valid` for one cycle. Transition: go back to ST_IDLE.

Top module: `vsw_forwarder`

## Requirements
- R1: The resolved VLAN reported on `res_vid` is the ingress port's default VLAN for an untagged frame (`hdr_tagged`=0), and the tag's VID for a tagged frame.
- R2: A frame is dropped at classification (`res_drop`=1, `res_egress`=0) in any of three cases: it is tagged and arrives on a port whose `cfg_tag_aware` bit is 0; its VLAN matches no VLAN table entry; or its ingress port is not in that entry's member mask.
- R3: When the destination MAC has been learned under the frame's VLAN, `res_egress` holds exactly the learned port's bit (bit i = port i). This holds if that port is a member of the VLAN.
- R4: When the destination is not learned under the frame's VLAN, `res_egress` holds only the VLAN's trunk port, if the entry enables one. If the entry enables no trunk port, the mask is empty.
- R5: The ingress port's bit is never set in `res_egress`. `res_drop` is 1 exactly when the reported mask is empty.
- R6: For each egress port, `res_tag_add` is set when that port is tag-aware and the frame arrived untagged. `res_tag_strip` is set when that port is tag-unaware and the frame arrived tagged. Both are 0 for ports outside the mask.
- R7: Every frame that passes classification is learned as (source MAC, VLAN) → ingress port. The same MAC under another VLAN is a separate entry.
- R8: When a frame's (source MAC, VLAN) is already learned on a different port, `move_event` pulses with `res_valid` and `move_old_port` gives the old port. The entry then points to the new port.
- R9: A frame dropped at classification is not learned.
- R10: `hdr_ready` is high only in ST_IDLE. For an accepted frame, `res_valid` rises after the 4th rising edge counted from the accepting edge; for a classification drop, it rises after the 2nd. `res_valid` lasts one cycle.
- R11: When every table entry is valid, a new source evicts entries in round-robin order starting at entry 0. Free entries are filled lowest index first, so the first-learned address is evicted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the address table |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Block is in ST_IDLE and takes the header |
| hdr_port | input | PORT_W | Ingress port number |
| hdr_dst_mac | input | 48 | Destination MAC |
| hdr_src_mac | input | 48 | Source MAC |
| hdr_tagged | input | 1 | Frame carries an 802.1Q tag |
| hdr_tag_vid | input | 12 | VID from the tag (ignored when untagged) |
| cfg_tag_aware | input | NUM_PORTS | Per-port tag awareness |
| cfg_port_pvid | input | NUM_PORTS*12 | Per-port default VLAN, port i at bits [12i+11:12i] |
| cfg_vlan_vid | input | NUM_VLANS*12 | VLAN ID of each table entry |
| cfg_vlan_members | input | NUM_VLANS*NUM_PORTS | Member port mask of each entry |
| cfg_vlan_trunk_en | input | NUM_VLANS | Entry has a trunk port |
| cfg_vlan_trunk_port | input | NUM_VLANS*PORT_W | Trunk port of each entry |
| res_valid | output | 1 | Result pulse |
| res_vid | output | 12 | Resolved VLAN |
| res_egress | output | NUM_PORTS | Egress port mask |
| res_tag_add | output | NUM_PORTS | Insert tag on these egress ports |
| res_tag_strip | output | NUM_PORTS | Remove tag on these egress ports |
| res_drop | output | 1 | Frame goes nowhere |
| move_event | output | 1 | Known station changed port |
| move_old_port | output | PORT_W | Port the station was learned on before |

## Verification
A stale or corrupt address entry shows up on the next frame addressed to that station. The mask then names the wrong port, or falls back to the trunk port, in that frame's report four cycles after it is accepted. A wrong state in the sequencer shows at once as a changed report latency or a `hdr_ready` that does not fall. A wrong classification register shows as a mismatch between the drop flag, the reported VLAN and the mask. Learning faults are exposed by sending a frame that depends on a previously learned, moved or evicted station, in both directions and across VLANs.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
    localparam int MAC_W = 48;
    localparam int VID_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_LOOKUP,
        ST_LEARN,
        ST_REPORT
    } vsw_state_e;
endpackage

// File: rtl/vsw_classify.sv
// Resolves the VLAN of a header and decides whether the ingress port may carry it.
module vsw_classify
    import vsw_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_VLANS = 4,
    parameter int PORT_W    = 2
) (
    input  logic [PORT_W-1:0]              in_port,
    input  logic                           in_tagged,
    input  logic [VID_W-1:0]               in_tag_vid,
    input  logic [NUM_PORTS-1:0]           cfg_tag_aware,
    input  logic [NUM_PORTS*VID_W-1:0]     cfg_port_pvid,
    input  logic [NUM_VLANS*VID_W-1:0]     cfg_vlan_vid,
    input  logic [NUM_VLANS*NUM_PORTS-1:0] cfg_vlan_members,
    input  logic [NUM_VLANS-1:0]           cfg_vlan_trunk_en,
    input  logic [NUM_VLANS*PORT_W-1:0]    cfg_vlan_trunk_port,
    output logic [VID_W-1:0]               cls_vid,
    output logic                           cls_accept,
    output logic [NUM_PORTS-1:0]           cls_members,
    output logic                           cls_trunk_valid,
    output logic [PORT_W-1:0]              cls_trunk_port
);
    logic [NUM_VLANS-1:0] vid_match;
    logic                 vlan_hit;
    logic                 port_aware;
    logic [VID_W-1:0]     port_pvid;

    always_comb begin
        port_aware = cfg_tag_aware[in_port];
        port_pvid  = cfg_port_pvid[in_port*VID_W +: VID_W];
        cls_vid    = in_tagged ? in_tag_vid : port_pvid;
    end

    for (genvar v = 0; v < NUM_VLANS; v++) begin : g_vid_cmp
        assign vid_match[v] = (cfg_vlan_vid[v*VID_W +: VID_W] == cls_vid);
    end

    // lowest-numbered matching entry wins
    always_comb begin
        vlan_hit        = 1'b0;
        cls_members     = '0;
        cls_trunk_valid = 1'b0;
        cls_trunk_port  = '0;
        for (int v = NUM_VLANS - 1; v >= 0; v--) begin
            if (vid_match[v]) begin
                vlan_hit        = 1'b1;
                cls_members     = cfg_vlan_members[v*NUM_PORTS +: NUM_PORTS];
                cls_trunk_valid = cfg_vlan_trunk_en[v];
                cls_trunk_port  = cfg_vlan_trunk_port[v*PORT_W +: PORT_W];
            end
        end
        cls_accept = vlan_hit && !(in_tagged && !port_aware) && cls_members[in_port];
    end
endmodule

// File: rtl/vsw_mac_table.sv
// Address table keyed on (MAC, VLAN); fully associative, round-robin replacement when full.
module vsw_mac_table
    import vsw_pkg::*;
#(
    parameter int TABLE_DEPTH = 8,
    parameter int PORT_W      = 2,
    localparam int IDX_W      = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAC_W-1:0]  look_dst_mac,
    input  logic [MAC_W-1:0]  look_src_mac,
    input  logic [VID_W-1:0]  look_vid,
    input  logic              learn_en,
    input  logic [PORT_W-1:0] learn_port,
    output logic              dst_hit,
    output logic [PORT_W-1:0] dst_port,
    output logic              src_hit,
    output logic [PORT_W-1:0] src_port
);
    logic [TABLE_DEPTH-1:0] ent_valid;
    logic [MAC_W-1:0]       ent_mac  [TABLE_DEPTH];
    logic [VID_W-1:0]       ent_vid  [TABLE_DEPTH];
    logic [PORT_W-1:0]      ent_port [TABLE_DEPTH];

    logic [TABLE_DEPTH-1:0] dst_match;
    logic [TABLE_DEPTH-1:0] src_match;
    logic [IDX_W-1:0]       src_idx;
    logic                   free_hit;
    logic [IDX_W-1:0]       free_idx;
    logic [IDX_W-1:0]       victim;
    logic [IDX_W-1:0]       wr_idx;

    for (genvar i = 0; i < TABLE_DEPTH; i++) begin : g_cmp
        assign dst_match[i] = ent_valid[i] && (ent_mac[i] == look_dst_mac) && (ent_vid[i] == look_vid);
        assign src_match[i] = ent_valid[i] && (ent_mac[i] == look_src_mac) && (ent_vid[i] == look_vid);
    end

    always_comb begin
        dst_hit  = 1'b0;
        dst_port = '0;
        src_hit  = 1'b0;
        src_port = '0;
        src_idx  = '0;
        free_hit = 1'b0;
        free_idx = '0;
        for (int i = TABLE_DEPTH - 1; i >= 0; i--) begin
            if (dst_match[i]) begin
                dst_hit  = 1'b1;
                dst_port = ent_port[i];
            end
            if (src_match[i]) begin
                src_hit  = 1'b1;
                src_port = ent_port[i];
                src_idx  = IDX_W'(i);
            end
            if (!ent_valid[i]) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        wr_idx = src_hit ? src_idx : (free_hit ? free_idx : victim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            victim    <= '0;
        end else if (learn_en) begin
            ent_valid[wr_idx] <= 1'b1;
            if (!src_hit && !free_hit) begin
                victim <= (victim == IDX_W'(TABLE_DEPTH - 1)) ? '0 : victim + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (learn_en) begin
            ent_mac[wr_idx]  <= look_src_mac;
            ent_vid[wr_idx]  <= look_vid;
            ent_port[wr_idx] <= learn_port;
        end
    end

    assert_victim_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        learn_en && !src_hit && !free_hit |=> victim != $past(victim) || TABLE_DEPTH == 1)
        else $error("victim pointer did not advance on eviction");
endmodule

// File: rtl/vsw_egress.sv
// Builds the egress mask and per-port tag actions from the lookup verdict.
module vsw_egress #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic [PORT_W-1:0]    in_port,
    input  logic                 in_tagged,
    input  logic [NUM_PORTS-1:0] cfg_tag_aware,
    input  logic [NUM_PORTS-1:0] members,
    input  logic                 dst_hit,
    input  logic [PORT_W-1:0]    dst_port,
    input  logic                 trunk_valid,
    input  logic [PORT_W-1:0]    trunk_port,
    output logic [NUM_PORTS-1:0] egress,
    output logic [NUM_PORTS-1:0] tag_add,
    output logic [NUM_PORTS-1:0] tag_strip
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic target;
        always_comb begin
            if (dst_hit)
                target = (dst_port == PORT_W'(p));
            else if (trunk_valid)
                target = (trunk_port == PORT_W'(p));
            else
                target = 1'b0;
            egress[p]    = target && members[p] && (in_port != PORT_W'(p));
            tag_add[p]   = egress[p] && cfg_tag_aware[p] && !in_tagged;
            tag_strip[p] = egress[p] && !cfg_tag_aware[p] && in_tagged;
        end
    end
endmodule

// File: rtl/vsw_forwarder.sv
module vsw_forwarder
    import vsw_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_VLANS   = 4,
    parameter int TABLE_DEPTH = 8,
    localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hdr_valid,
    output logic                           hdr_ready,
    input  logic [PORT_W-1:0]              hdr_port,
    input  logic [MAC_W-1:0]               hdr_dst_mac,
    input  logic [MAC_W-1:0]               hdr_src_mac,
    input  logic                           hdr_tagged,
    input  logic [VID_W-1:0]               hdr_tag_vid,
    input  logic [NUM_PORTS-1:0]           cfg_tag_aware,
    input  logic [NUM_PORTS*VID_W-1:0]     cfg_port_pvid,
    input  logic [NUM_VLANS*VID_W-1:0]     cfg_vlan_vid,
    input  logic [NUM_VLANS*NUM_PORTS-1:0] cfg_vlan_members,
    input  logic [NUM_VLANS-1:0]           cfg_vlan_trunk_en,
    input  logic [NUM_VLANS*PORT_W-1:0]    cfg_vlan_trunk_port,
    output logic                           res_valid,
    output logic [VID_W-1:0]               res_vid,
    output logic [NUM_PORTS-1:0]           res_egress,
    output logic [NUM_PORTS-1:0]           res_tag_add,
    output logic [NUM_PORTS-1:0]           res_tag_strip,
    output logic                           res_drop,
    output logic                           move_event,
    output logic [PORT_W-1:0]              move_old_port
);
    vsw_state_e state, state_nx;

    // latched header
    logic [PORT_W-1:0]    in_port_q;
    logic [MAC_W-1:0]     dst_q, src_q;
    logic                 tagged_q;
    logic [VID_W-1:0]     tag_vid_q;
    // classification verdict
    logic [VID_W-1:0]     vid_q;
    logic                 accept_q;
    logic [NUM_PORTS-1:0] members_q;
    logic                 trunk_valid_q;
    logic [PORT_W-1:0]    trunk_port_q;
    // lookup verdict
    logic                 dst_hit_q;
    logic [PORT_W-1:0]    dst_port_q;
    logic                 move_q;
    logic [PORT_W-1:0]    old_port_q;
    // result
    logic [NUM_PORTS-1:0] egress_q, add_q, strip_q;

    logic [VID_W-1:0]     cls_vid;
    logic                 cls_accept;
    logic [NUM_PORTS-1:0] cls_members;
    logic                 cls_trunk_valid;
    logic [PORT_W-1:0]    cls_trunk_port;
    logic                 tbl_dst_hit, tbl_src_hit;
    logic [PORT_W-1:0]    tbl_dst_port, tbl_src_port;
    logic [NUM_PORTS-1:0] eg_mask, eg_add, eg_strip;
    logic                 learn_en;

    vsw_classify #(.NUM_PORTS(NUM_PORTS), .NUM_VLANS(NUM_VLANS), .PORT_W(PORT_W)) u_classify (
        .in_port             (in_port_q),
        .in_tagged           (tagged_q),
        .in_tag_vid          (tag_vid_q),
        .cfg_tag_aware       (cfg_tag_aware),
        .cfg_port_pvid       (cfg_port_pvid),
        .cfg_vlan_vid        (cfg_vlan_vid),
        .cfg_vlan_members    (cfg_vlan_members),
        .cfg_vlan_trunk_en   (cfg_vlan_trunk_en),
        .cfg_vlan_trunk_port (cfg_vlan_trunk_port),
        .cls_vid             (cls_vid),
        .cls_accept          (cls_accept),
        .cls_members         (cls_members),
        .cls_trunk_valid     (cls_trunk_valid),
        .cls_trunk_port      (cls_trunk_port)
    );

    assign learn_en = (state == ST_LEARN);

    vsw_mac_table #(.TABLE_DEPTH(TABLE_DEPTH), .PORT_W(PORT_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_dst_mac (dst_q),
        .look_src_mac (src_q),
        .look_vid     (vid_q),
        .learn_en     (learn_en),
        .learn_port   (in_port_q),
        .dst_hit      (tbl_dst_hit),
        .dst_port     (tbl_dst_port),
        .src_hit      (tbl_src_hit),
        .src_port     (tbl_src_port)
    );

    vsw_egress #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_egress (
        .in_port       (in_port_q),
        .in_tagged     (tagged_q),
        .cfg_tag_aware (cfg_tag_aware),
        .members       (members_q),
        .dst_hit       (dst_hit_q),
        .dst_port      (dst_port_q),
        .trunk_valid   (trunk_valid_q),
        .trunk_port    (trunk_port_q),
        .egress        (eg_mask),
        .tag_add       (eg_add),
        .tag_strip     (eg_strip)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (hdr_valid) state_nx = ST_CLASSIFY;
            ST_CLASSIFY: state_nx = cls_accept ? ST_LOOKUP : ST_REPORT;
            ST_LOOKUP:   state_nx = ST_LEARN;
            ST_LEARN:    state_nx = ST_REPORT;
            ST_REPORT:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // per-state datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_port_q     <= '0;
            dst_q         <= '0;
            src_q         <= '0;
            tagged_q      <= 1'b0;
            tag_vid_q     <= '0;
            vid_q         <= '0;
            accept_q      <= 1'b0;
            members_q     <= '0;
            trunk_valid_q <= 1'b0;
            trunk_port_q  <= '0;
            dst_hit_q     <= 1'b0;
            dst_port_q    <= '0;
            move_q        <= 1'b0;
            old_port_q    <= '0;
            egress_q      <= '0;
            add_q         <= '0;
            strip_q       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (hdr_valid) begin
                        in_port_q <= hdr_port;
                        dst_q     <= hdr_dst_mac;
                        src_q     <= hdr_src_mac;
                        tagged_q  <= hdr_tagged;
                        tag_vid_q <= hdr_tag_vid;
                    end
                end
                ST_CLASSIFY: begin
                    vid_q         <= cls_vid;
                    accept_q      <= cls_accept;
                    members_q     <= cls_members;
                    trunk_valid_q <= cls_trunk_valid;
                    trunk_port_q  <= cls_trunk_port;
                    move_q        <= 1'b0;
                    egress_q      <= '0;
                    add_q         <= '0;
                    strip_q       <= '0;
                end
                ST_LOOKUP: begin
                    dst_hit_q  <= tbl_dst_hit;
                    dst_port_q <= tbl_dst_port;
                    move_q     <= tbl_src_hit && (tbl_src_port != in_port_q);
                    old_port_q <= tbl_src_port;
                end
                ST_LEARN: begin
                    egress_q <= eg_mask;
                    add_q    <= eg_add;
                    strip_q  <= eg_strip;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        hdr_ready     = (state == ST_IDLE);
        res_valid     = (state == ST_REPORT);
        res_vid       = vid_q;
        res_egress    = egress_q;
        res_tag_add   = add_q;
        res_tag_strip = strip_q;
        res_drop      = !accept_q || (egress_q == '0);
        move_event    = res_valid && move_q;
        move_old_port = old_port_q;
    end

    assert_no_reflect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !res_egress[in_port_q])
        else $error("egress mask includes the ingress port");

    assert_drop_iff_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_drop == (res_egress == '0)))
        else $error("drop flag disagrees with egress mask");

    assert_class_drop_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !accept_q |-> (res_egress == '0) && (res_tag_add == '0) && (res_tag_strip == '0))
        else $error("classified drop left a non-empty result");

    assert_unicast_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0(res_egress))
        else $error("unicast egress mask has more than one port");

    assert_tag_within_egress_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (((res_tag_add | res_tag_strip) & ~res_egress) == '0) && ((res_tag_add & res_tag_strip) == '0))
        else $error("tag action outside egress mask");

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && hdr_ready)
        else $error("result not a single pulse followed by ready");

    assert_move_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
        move_event |-> res_valid && (move_old_port != in_port_q))
        else $error("move event malformed");

    assert_learn_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        learn_en |=> tbl_src_hit && (tbl_src_port == $past(in_port_q)))
        else $error("learned source not found in table");
endmodule

// File: tb/vsw_forwarder_bench.sv
module vsw_forwarder_bench;
    localparam int P  = 4;
    localparam int NV = 4;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdr_valid = 1'b0;
    logic hdr_ready;
    logic [PW-1:0] hdr_port = '0;
    logic [47:0] hdr_dst_mac = '0, hdr_src_mac = '0;
    logic hdr_tagged = 1'b0;
    logic [11:0] hdr_tag_vid = '0;
    logic res_valid, res_drop, move_event;
    logic [11:0] res_vid;
    logic [P-1:0] res_egress, res_tag_add, res_tag_strip;
    logic [PW-1:0] move_old_port;

    // ports 0,1 tag-aware; 2,3 unaware; PVIDs 10,10,10,20
    // VLAN 10: members {0,1,2}, trunk 1; VLAN 20: {0,3}, no trunk;
    // VLAN 30: {0,1}, trunk 0; VLAN 40: no members
    logic [P-1:0]     cfg_aware   = 4'b0011;
    logic [P*12-1:0]  cfg_pvid    = {12'd20, 12'd10, 12'd10, 12'd10};
    logic [NV*12-1:0] cfg_vid     = {12'd40, 12'd30, 12'd20, 12'd10};
    logic [NV*P-1:0]  cfg_members = {4'b0000, 4'b0011, 4'b1001, 4'b0111};
    logic [NV-1:0]    cfg_trk_en  = 4'b0101;
    logic [NV*PW-1:0] cfg_trk_pt  = {2'd0, 2'd0, 2'd0, 2'd1};

    always #4 clk = ~clk;

    vsw_forwarder u_vsw_forwarder (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_port(hdr_port), .hdr_dst_mac(hdr_dst_mac), .hdr_src_mac(hdr_src_mac),
        .hdr_tagged(hdr_tagged), .hdr_tag_vid(hdr_tag_vid),
        .cfg_tag_aware(cfg_aware), .cfg_port_pvid(cfg_pvid), .cfg_vlan_vid(cfg_vid),
        .cfg_vlan_members(cfg_members), .cfg_vlan_trunk_en(cfg_trk_en),
        .cfg_vlan_trunk_port(cfg_trk_pt),
        .res_valid(res_valid), .res_vid(res_vid), .res_egress(res_egress),
        .res_tag_add(res_tag_add), .res_tag_strip(res_tag_strip), .res_drop(res_drop),
        .move_event(move_event), .move_old_port(move_old_port)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic [47:0] mac(input int n);
        return {8'h02, 32'h0, n[7:0]};
    endfunction

    // captured result of last frame
    int lat;
    logic c_drop, c_move;
    logic [11:0] c_vid;
    logic [P-1:0] c_eg, c_add, c_strip;
    logic [PW-1:0] c_old;

    task automatic send(input int port, input int src, input int dst, input bit tg, input int vid);
        @(negedge clk);
        chk("R10", "ready before accept", int'(hdr_ready), 1);
        hdr_port    = PW'(port);
        hdr_src_mac = mac(src);
        hdr_dst_mac = mac(dst);
        hdr_tagged  = tg;
        hdr_tag_vid = 12'(vid);
        hdr_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R10", "ready while busy", int'(hdr_ready), 0);
        lat = 1;
        while (!res_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        c_drop = res_drop; c_move = move_event; c_vid = res_vid;
        c_eg = res_egress; c_add = res_tag_add; c_strip = res_tag_strip; c_old = move_old_port;
        @(negedge clk);
        chk("R10", "result pulse width", int'(res_valid), 0);
    endtask

    typedef struct packed {
        logic [1:0]  port;
        logic [7:0]  src;
        logic [7:0]  dst;
        logic        tg;
        logic [11:0] vid;
        logic        drop;
        logic [11:0] evid;
        logic [3:0]  eg;
        logic [3:0]  add;
        logic [3:0]  strip;
        logic        mv;
        logic [1:0]  oldp;
        logic [2:0]  lat;
    } vec_t;

    localparam int NVEC = 16;
    localparam logic [61:0] VEC [NVEC] = '{
        // R1 R4 R6: untagged on p2, unknown dst -> trunk p1, add tag
        {2'd2, 8'd1, 8'd2, 1'b0, 12'd0,  1'b0, 12'd10, 4'b0010, 4'b0010, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R3 R6: tagged p1 to learned A on unaware p2, strip
        {2'd1, 8'd2, 8'd1, 1'b1, 12'd10, 1'b0, 12'd10, 4'b0100, 4'b0000, 4'b0100, 1'b0, 2'd0, 3'd4},
        // R3: tagged aware->aware, no action
        {2'd0, 8'd3, 8'd2, 1'b1, 12'd10, 1'b0, 12'd10, 4'b0010, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R3 R6: untagged p2 to C on aware p0, add
        {2'd2, 8'd1, 8'd3, 1'b0, 12'd0,  1'b0, 12'd10, 4'b0001, 4'b0001, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R1 R4 R7: p3 PVID 20, A unknown in VLAN 20, no trunk -> drop
        {2'd3, 8'd4, 8'd1, 1'b0, 12'd0,  1'b1, 12'd20, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R3 R6: tagged 20 to D on unaware p3, strip
        {2'd0, 8'd5, 8'd4, 1'b1, 12'd20, 1'b0, 12'd20, 4'b1000, 4'b0000, 4'b1000, 1'b0, 2'd0, 3'd4},
        // R2: tagged frame on unaware p2
        {2'd2, 8'd6, 8'd1, 1'b1, 12'd10, 1'b1, 12'd10, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd2},
        // R2: VID 99 not in table
        {2'd0, 8'd6, 8'd1, 1'b1, 12'd99, 1'b1, 12'd99, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd2},
        // R2: p1 not member of VLAN 20
        {2'd1, 8'd7, 8'd1, 1'b1, 12'd20, 1'b1, 12'd20, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd2},
        // R9: F only seen in dropped frames -> still unknown -> trunk p1
        {2'd0, 8'd3, 8'd6, 1'b1, 12'd10, 1'b0, 12'd10, 4'b0010, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R8: A moves from p2 to p1
        {2'd1, 8'd1, 8'd3, 1'b1, 12'd10, 1'b0, 12'd10, 4'b0001, 4'b0000, 4'b0000, 1'b1, 2'd2, 3'd4},
        // R8: A now reached on p1
        {2'd0, 8'd3, 8'd1, 1'b1, 12'd10, 1'b0, 12'd10, 4'b0010, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R5 R7: A unknown in VLAN 30, trunk is ingress p0 -> empty -> drop
        {2'd0, 8'd8, 8'd1, 1'b1, 12'd30, 1'b1, 12'd30, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R7: A learned in VLAN 30 separately, no move; H known on p0
        {2'd1, 8'd1, 8'd8, 1'b1, 12'd30, 1'b0, 12'd30, 4'b0001, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R5: dst B is on ingress p1 -> drop
        {2'd1, 8'd9, 8'd2, 1'b1, 12'd10, 1'b1, 12'd10, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd4},
        // R2: VLAN 40 has no members
        {2'd0, 8'd10, 8'd1, 1'b1, 12'd40, 1'b1, 12'd40, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 3'd2}
    };

    task automatic check_result(input string req, input int eg, input int add, input int strip, input int drop);
        chk(req, "egress", int'(c_eg), eg);
        chk(req, "tag add", int'(c_add), add);
        chk(req, "tag strip", int'(c_strip), strip);
        chk(req, "drop", int'(c_drop), drop);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset ready", int'(hdr_ready), 1);
        chk("R10", "reset valid", int'(res_valid), 0);
        chk("R8", "reset move", int'(move_event), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = vec_t'(VEC[i]);
            send(int'(v.port), int'(v.src), int'(v.dst), v.tg, int'(v.vid));
            chk("R10", $sformatf("vec %0d latency", i), lat, int'(v.lat));
            chk("R1", $sformatf("vec %0d vid", i), int'(c_vid), int'(v.evid));
            chk("R3", $sformatf("vec %0d egress", i), int'(c_eg), int'(v.eg));
            chk("R6", $sformatf("vec %0d tag add", i), int'(c_add), int'(v.add));
            chk("R6", $sformatf("vec %0d tag strip", i), int'(c_strip), int'(v.strip));
            chk("R5", $sformatf("vec %0d drop", i), int'(c_drop), int'(v.drop));
            chk("R8", $sformatf("vec %0d move", i), int'(c_move), int'(v.mv));
            if (v.mv) chk("R8", $sformatf("vec %0d old port", i), int'(c_old), int'(v.oldp));
        end

        // R11: table full, round-robin eviction from entry 0
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "ready after second reset", int'(hdr_ready), 1);
        rst_n = 1'b1;
        for (int n = 0; n < 9; n++) begin
            send(0, 16 + n, 100, 1'b1, 10);
            check_result("R11", 4'b0010, 0, 0, 0);
        end
        // source 200 evicts entry 1; 16 was evicted by source 24
        send(2, 200, 16, 1'b0, 0);
        check_result("R11", 4'b0010, 4'b0010, 0, 0);
        send(2, 200, 18, 1'b0, 0);
        check_result("R11", 4'b0001, 4'b0001, 0, 0);
        send(2, 200, 24, 1'b0, 0);
        check_result("R11", 4'b0001, 4'b0001, 0, 0);
        send(2, 200, 17, 1'b0, 0);
        check_result("R11", 4'b0010, 4'b0010, 0, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule